// File: doc/BRIEF.md
# Two-Level-Cached Four-Level Address Translator

This unit translates 32-bit virtual addresses into physical addresses for 4 KiB pages. Each request first goes to a small fully associative translation cache. On a hit, the unit returns the physical address without touching memory. On a miss, it walks a four-level table tree in memory. It reads one word per level, starting from the table whose base comes from the per-process root input. It then installs the finished translation in the cache.

The 20-bit page number is split into four 5-bit indices. The top index selects an entry in the root (level 4) table, and the bottom index selects the leaf (level 1) entry. Each table holds 32 four-byte entries, so a table is 128 bytes. An entry address is the table base with bits [6:0] replaced by `{index, 2'b00}`.

Entry format:
- bit 0 is the valid flag.
- For an inner entry, bits [31:7] give the base of the next table.
- For a leaf entry, bits [31:12] give the physical page number and bit 1 marks the page executable.

Each request carries a fetch flag. A fetch to a page without the executable mark returns a fault.

Top module: `addr_xlate`

## Requirements
- R1: A successful translation returns `{ppn, vaddr[11:0]}`: the page offset passes through unchanged.
- R2: A miss issues exactly four memory reads, from level 4 down to level 1. Each read is at `{base[31:7], index, 2'b00}`, where the level-4 base is `root_i[31:7]` and each later base is bits [31:7] of the entry just read. `mem_req_o` and `mem_addr_o` hold until `mem_ack_i`.
- R3: A hit issues no memory read. Its response is valid in the cycle right after the request is accepted.
- R4: An entry read with bit 0 clear ends the walk at once. The response has `rsp_fault_o`=1 and `rsp_flvl_o` equal to the failing level (4..1), and no translation is installed.
- R5: A request with `req_fetch_i`=1 to a page whose leaf bit 1 is clear faults with `rsp_flvl_o`=0, on both the hit path and the walk path. A data access to the same page succeeds.
- R6: The cache holds 8 translations. Installs fill slots in round-robin order, so the ninth distinct install evicts the oldest one. Hits do not move the pointer.
- R7: A `flush_i` pulse drops every cached translation, so the next access to any page walks again.
- R8: When `flush_i` falls in the same cycle as a leaf install, the flush wins. The walk still responds correctly, but nothing stays cached.
- R9: After reset, `ready_o`=1, `rsp_valid_o`=0 and `mem_req_o`=0.
- R10: `rsp_valid_o` is a one-cycle pulse. `ready_o` is low from acceptance until the response has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cached translations |
| root_i | input | 32 | Root table base (bits [6:0] ignored) |
| req_valid_i | input | 1 | Translation request, taken when ready_o is high |
| req_vaddr_i | input | 32 | Virtual address |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| ready_o | output | 1 | Unit idle, can accept a request |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_flvl_o | output | 3 | Failing level 1..4, or 0 for execute violation |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table entry byte address |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 32 | Table entry read |

## Verification
The conflict to cover is a flush in the same cycle as a leaf install at the end of a walk. The bench's memory model raises `flush_i` together with the acknowledge of the leaf-table read, so both land on one clock edge. The walk's own response must still be correct. A second access to the same page must then perform four fresh reads, which shows that the flush won over the install.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 5;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = VPN_W;
  localparam int TBL_W  = IDX_W + 2;          // 128-byte table alignment
  localparam int BASE_W = VA_W - TBL_W;
  localparam int PTE_V  = 0;
  localparam int PTE_X  = 1;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             exec;
  } tlb_ent_t;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic             lk_exec_o,
  input  logic             ins_i,
  input  logic [VPN_W-1:0] ins_vpn_i,
  input  logic [PPN_W-1:0] ins_ppn_i,
  input  logic             ins_exec_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  tlb_ent_t         ent_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_q[g].valid && (ent_q[g].vpn == lk_vpn_i);
  end

  always_comb begin
    lk_hit_o  = 1'b0;
    lk_ppn_o  = '0;
    lk_exec_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        lk_hit_o  = 1'b1;
        lk_ppn_o  = lk_ppn_o | ent_q[i].ppn;
        lk_exec_o = lk_exec_o | ent_q[i].exec;
      end
    end
  end

  // flush beats a same-cycle install
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      ptr_q <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i].valid <= 1'b0;
      ptr_q <= '0;
    end else if (ins_i) begin
      ent_q[ptr_q] <= '{valid: 1'b1, vpn: ins_vpn_i, ppn: ins_ppn_i, exec: ins_exec_i};
      ptr_q        <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  root_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_fetch_i,
  output logic             ready_o,
  input  logic             tlb_hit_i,
  input  logic [PPN_W-1:0] tlb_ppn_i,
  input  logic             tlb_exec_i,
  output logic             ins_o,
  output logic [VPN_W-1:0] ins_vpn_o,
  output logic [PPN_W-1:0] ins_ppn_o,
  output logic             ins_exec_o,
  output logic             rsp_valid_o,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic [2:0]       rsp_flvl_o,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [VA_W-1:0]  mem_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} st_e;

  st_e               st_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic              fetch_q;
  logic [2:0]        lvl_q;
  logic [BASE_W-1:0] base_q;
  logic [VA_W-1:0]   paddr_q;
  logic              fault_q;
  logic [2:0]        flvl_q;
  logic [IDX_W-1:0]  idx;
  logic              pte_ok, leaf_done;
  logic              unused_bits;

  assign unused_bits = ^{root_i[TBL_W-1:0], mem_rdata_i[TBL_W-1:PTE_X+1]};

  always_comb begin
    unique case (lvl_q)
      3'd4:    idx = vpn_q[4*IDX_W-1:3*IDX_W];
      3'd3:    idx = vpn_q[3*IDX_W-1:2*IDX_W];
      3'd2:    idx = vpn_q[2*IDX_W-1:IDX_W];
      default: idx = vpn_q[IDX_W-1:0];
    endcase
  end

  assign pte_ok     = mem_rdata_i[PTE_V];
  assign leaf_done  = (st_q == S_WALK) && mem_ack_i && pte_ok && (lvl_q == 3'd1);

  assign ready_o     = (st_q == S_IDLE);
  assign mem_req_o   = (st_q == S_WALK);
  assign mem_addr_o  = {base_q, idx, 2'b00};
  assign rsp_valid_o = (st_q == S_DONE);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
  assign rsp_flvl_o  = flvl_q;

  assign ins_o      = leaf_done;
  assign ins_vpn_o  = vpn_q;
  assign ins_ppn_o  = mem_rdata_i[VA_W-1:OFF_W];
  assign ins_exec_o = mem_rdata_i[PTE_X];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      fetch_q <= 1'b0;
      lvl_q   <= 3'd4;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vaddr_i[VA_W-1:OFF_W];
          off_q   <= req_vaddr_i[OFF_W-1:0];
          fetch_q <= req_fetch_i;
          if (tlb_hit_i) begin
            fault_q <= req_fetch_i && !tlb_exec_i;
            paddr_q <= (req_fetch_i && !tlb_exec_i) ? '0 :
                       {tlb_ppn_i, req_vaddr_i[OFF_W-1:0]};
            flvl_q  <= '0;
            st_q    <= S_DONE;
          end else begin
            lvl_q  <= 3'd4;
            base_q <= root_i[VA_W-1:TBL_W];
            st_q   <= S_WALK;
          end
        end
        S_WALK: if (mem_ack_i) begin
          if (!pte_ok) begin
            fault_q <= 1'b1;
            flvl_q  <= lvl_q;
            paddr_q <= '0;
            st_q    <= S_DONE;
          end else if (lvl_q == 3'd1) begin
            fault_q <= fetch_q && !mem_rdata_i[PTE_X];
            paddr_q <= (fetch_q && !mem_rdata_i[PTE_X]) ? '0 :
                       {mem_rdata_i[VA_W-1:OFF_W], off_q};
            flvl_q  <= '0;
            st_q    <= S_DONE;
          end else begin
            base_q <= mem_rdata_i[VA_W-1:TBL_W];
            lvl_q  <= lvl_q - 3'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int TLB_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic [31:0] root_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_vaddr_i,
  input  logic        req_fetch_i,
  output logic        ready_o,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_paddr_o,
  output logic        rsp_fault_o,
  output logic [2:0]  rsp_flvl_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);
  logic             tlb_hit, tlb_exec, ins, ins_exec;
  logic [PPN_W-1:0] tlb_ppn, ins_ppn;
  logic [VPN_W-1:0] ins_vpn;

  xlate_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .lk_vpn_i   (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_hit_o   (tlb_hit),
    .lk_ppn_o   (tlb_ppn),
    .lk_exec_o  (tlb_exec),
    .ins_i      (ins),
    .ins_vpn_i  (ins_vpn),
    .ins_ppn_i  (ins_ppn),
    .ins_exec_i (ins_exec)
  );

  xlate_walker u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .root_i      (root_i),
    .req_valid_i (req_valid_i),
    .req_vaddr_i (req_vaddr_i),
    .req_fetch_i (req_fetch_i),
    .ready_o     (ready_o),
    .tlb_hit_i   (tlb_hit),
    .tlb_ppn_i   (tlb_ppn),
    .tlb_exec_i  (tlb_exec),
    .ins_o       (ins),
    .ins_vpn_o   (ins_vpn),
    .ins_ppn_o   (ins_ppn),
    .ins_exec_o  (ins_exec),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_flvl_o  (rsp_flvl_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_vaddr_i,
  input logic        ready_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_paddr_o,
  input logic        rsp_fault_o,
  input logic [2:0]  rsp_flvl_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i
);
  logic [11:0] off_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_seen <= '0;
    else if (req_valid_i && ready_o) off_seen <= req_vaddr_i[11:0];
  end

  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[11:0] == off_seen);
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  a_r3_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);
  a_r4_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_flvl_o <= 3'd4);
  a_r10_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ready_o |=> !ready_o);
endmodule

bind addr_xlate xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .ready_o     (ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_flvl_o  (rsp_flvl_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/addr_xlate_tb.sv
`timescale 1ns/100ps
module addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_cmd = 1'b0, leaf_flush = 1'b0, leaf_arm = 1'b0;
  logic        flush;
  logic        req_valid = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic [2:0]  rsp_flvl;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [1024];
  logic [31:0] rd_log [8];
  int          nreads = 0;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  assign flush = flush_cmd | leaf_flush;
  always #2.5 clk = ~clk;

  addr_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .root_i(32'h0000_0000),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_fetch_i(req_fetch),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_flvl_o(rsp_flvl), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata));

  // memory model: ack one cycle after request seen, optional flush on leaf read
  initial forever begin
    @(posedge clk); #1;
    leaf_flush = 1'b0;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack   = 1'b1;
      mem_rdata = mem[mem_addr[11:2]];
      if (nreads < 8) rd_log[nreads] = mem_addr;
      nreads++;
      if (leaf_arm && mem_addr[11:7] == 5'd3) leaf_flush = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input int k, input logic [11:0] off);
    return {5'd1, 5'd2, 5'd3, 5'(k), off};
  endfunction

  function automatic logic [19:0] ppn_of(input int k);
    return 20'hA0000 + 20'(k);
  endfunction

  int r_reads, r_lat;
  logic [31:0] r_paddr;
  logic r_fault;
  logic [2:0] r_flvl;

  task automatic xlate(input logic [31:0] v, input logic f);
    int base;
    while (!ready) begin @(posedge clk); #1; end
    base = nreads;
    req_vaddr = v; req_fetch = f; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid) begin
      chk("R10 busy", {31'd0, ready}, 32'd0);
      @(posedge clk); #1; r_lat++;
    end
    r_paddr = rsp_paddr; r_fault = rsp_fault; r_flvl = rsp_flvl;
    r_reads = nreads - base;
    @(posedge clk); #1;
    chk("R10 pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic do_flush;
    flush_cmd = 1'b1; @(posedge clk); #1; flush_cmd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 ready", {31'd0, ready}, 32'd1);
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_walk;
    xlate(va(3, 12'hABC), 1'b0);
    chk("R2 reads", r_reads, 4);
    chk("R2 addr l4", rd_log[0], 32'h0000_0004);
    chk("R2 addr l3", rd_log[1], 32'h0000_0088);
    chk("R2 addr l2", rd_log[2], 32'h0000_010C);
    chk("R2 addr l1", rd_log[3], 32'h0000_018C);
    chk("R1 paddr", r_paddr, {ppn_of(3), 12'hABC});
    chk("R1 fault", {31'd0, r_fault}, 32'd0);
  endtask

  task automatic t_hit;
    xlate(va(3, 12'h123), 1'b0);
    chk("R3 reads", r_reads, 0);
    chk("R3 latency", r_lat, 0);
    chk("R3 paddr", r_paddr, {ppn_of(3), 12'h123});
  endtask

  task automatic t_faults;
    xlate({5'd6, 15'd0, 12'h010}, 1'b0);
    chk("R4 l4 fault", {31'd0, r_fault}, 32'd1);
    chk("R4 l4 level", {29'd0, r_flvl}, 32'd4);
    chk("R4 l4 reads", r_reads, 1);
    xlate({5'd2, 5'd7, 10'd0, 12'h020}, 1'b0);
    chk("R4 l3 level", {29'd0, r_flvl}, 32'd3);
    chk("R4 l3 reads", r_reads, 2);
    xlate(va(21, 12'h0), 1'b0);
    chk("R4 l1 level", {29'd0, r_flvl}, 32'd1);
    chk("R4 l1 reads", r_reads, 4);
    xlate(va(21, 12'h4), 1'b0);
    chk("R4 no install", r_reads, 4);
    chk("R4 l1 again", {31'd0, r_fault}, 32'd1);
  endtask

  task automatic t_exec;
    xlate(va(22, 12'h0), 1'b1);
    chk("R5 walk fetch fault", {31'd0, r_fault}, 32'd1);
    chk("R5 walk fetch code", {29'd0, r_flvl}, 32'd0);
    xlate(va(22, 12'h8), 1'b0);
    chk("R5 data ok", {31'd0, r_fault}, 32'd0);
    chk("R5 data hit", r_reads, 0);
    xlate(va(20, 12'h44), 1'b0);
    chk("R5 data paddr", r_paddr, {ppn_of(20), 12'h44});
    xlate(va(20, 12'h48), 1'b1);
    chk("R5 hit fetch fault", {31'd0, r_fault}, 32'd1);
    chk("R5 hit fetch code", {29'd0, r_flvl}, 32'd0);
    chk("R5 hit no read", r_reads, 0);
    xlate(va(3, 12'h0), 1'b1);
    chk("R5 exec page ok", {31'd0, r_fault}, 32'd0);
  endtask

  task automatic t_flush;
    do_flush();
    xlate(va(3, 12'h5), 1'b0);
    chk("R7 rewalk", r_reads, 4);
    chk("R7 paddr", r_paddr, {ppn_of(3), 12'h5});
  endtask

  task automatic t_rr;
    do_flush();
    for (int k = 0; k < 8; k++) begin
      xlate(va(k, 12'h0), 1'b0);
      chk("R6 fill", r_reads, 4);
    end
    for (int k = 0; k < 8; k++) begin
      xlate(va(k, 12'h1), 1'b0);
      chk("R6 all hit", r_reads, 0);
      chk("R6 hit paddr", r_paddr, {ppn_of(k), 12'h1});
    end
    xlate(va(8, 12'h0), 1'b0);
    chk("R6 ninth walks", r_reads, 4);
    xlate(va(1, 12'h0), 1'b0);
    chk("R6 second kept", r_reads, 0);
    xlate(va(0, 12'h0), 1'b0);
    chk("R6 oldest evicted", r_reads, 4);
    xlate(va(2, 12'h0), 1'b0);
    chk("R6 third kept", r_reads, 0);
    xlate(va(1, 12'h0), 1'b0);
    chk("R6 second evicted", r_reads, 4);
  endtask

  task automatic t_flush_install;
    do_flush();
    leaf_arm = 1'b1;
    xlate(va(4, 12'h77), 1'b0);
    leaf_arm = 1'b0;
    chk("R8 walk reads", r_reads, 4);
    chk("R8 paddr", r_paddr, {ppn_of(4), 12'h77});
    xlate(va(4, 12'h78), 1'b0);
    chk("R8 not cached", r_reads, 4);
    xlate(va(4, 12'h79), 1'b0);
    chk("R8 later install", r_reads, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[1]        = 32'h0000_0081;           // root[1] -> 0x080
    mem[2]        = 32'h0000_0201;           // root[2] -> 0x200
    mem[32 + 2]   = 32'h0000_0101;           // 0x080[2] -> 0x100
    mem[64 + 3]   = 32'h0000_0181;           // 0x100[3] -> 0x180
    for (int k = 0; k < 23; k++)
      mem[96 + k] = {ppn_of(k), 10'd0, 1'b1, 1'b1};
    mem[96 + 20]  = {ppn_of(20), 12'h001};   // not executable
    mem[96 + 22]  = {ppn_of(22), 12'h001};   // not executable
    mem[96 + 21]  = 32'h0;                   // invalid leaf
    #12; rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_walk();
    t_hit();
    t_faults();
    t_exec();
    t_flush();
    t_rr();
    t_flush_install();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule